// File: doc/BRIEF.md
# UART FIFO Interrupt Status Controller

This block forms the interrupt word and the interrupt request lines for a UART whose transmit queue holds 32 bytes and whose receive queue holds 64. It takes the live occupancy of both queues, the two coded watermark level fields, and one-cycle pulses from the receive path for error and timeout events. From these it drives the readable interrupt word and one request line per source.

The interrupt word mixes two kinds of bit. The three queue-level bits (transmit below watermark, receive at or above watermark, transmit empty) carry no storage: they follow the queue levels and the level codes combinationally in every cycle, and software cannot clear them. The remaining bits latch on an event pulse and stay set until software writes 1 to them. A small register port gives access to the interrupt word (write-1-to-clear), the enable mask and a test register that injects interrupts.

The level codes decode to thresholds of two to the power of the code, clamped to a limit derived from the queue depths. The receive code's highest value turns the receive watermark off.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Interrupt bit 2 (transmit empty) reads 1 exactly when `tx_level_i` is 0.
- R2: Interrupt bit 0 (transmit watermark) reads 1 exactly when `tx_level_i` is strictly below the transmit threshold. The threshold is min(2^code, 16), where code is `tx_lvl_code_i` (0..7).
- R3: Interrupt bit 1 (receive watermark) reads 1 exactly when `rx_level_i` is at or above the receive threshold. The threshold is min(2^code, 62) for `rx_lvl_code_i` values 0..6.
- R4: When `rx_lvl_code_i` is 7, interrupt bit 1 reads 0 whatever the receive level.
- R5: Bits 0..2 are not stored. A change of level or of level code shows on `intr_state_o` and `irq_o` in the same cycle, with no clock edge in between.
- R6: A 1 on `evt_i[k]` in a cycle sets interrupt bit 3+k from the next cycle on. The bit stays set until it is cleared.
- R7: A write to address 0 clears each interrupt bit 3 and above whose write-data bit is 1. Bits 0..2 and event bits written with 0 are unaffected.
- R8: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R9: A write to address 2 sets every event bit whose write-data bit is 1. Each status bit (0..2) written with 1 is forced to 1 for exactly the one cycle that follows the write.
- R10: A write to address 1 loads the enable mask. `irq_o` equals the interrupt word ANDed with the mask. Reading address 1 returns the mask, reading address 0 returns the interrupt word, and reading address 3 returns 0.
- R11: After reset all event bits and the enable mask are 0, so `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| tx_level_i | input | 6 | Current transmit queue occupancy, 0..32 |
| rx_level_i | input | 7 | Current receive queue occupancy, 0..64 |
| tx_lvl_code_i | input | 3 | Coded transmit watermark level |
| rx_lvl_code_i | input | 3 | Coded receive watermark level, 7 = off |
| evt_i | input | 5 | One-cycle event pulses, bit k drives interrupt bit 3+k |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 interrupt word, 1 enable, 2 test |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| intr_state_o | output | 8 | Interrupt word: status bits ORed with latched event bits |
| irq_o | output | 8 | Interrupt request lines, one per bit |

## Verification
The bench targets the threshold edges of every level code: the level one below the threshold and the level at it. This includes the clamped codes, where a decoder that did not saturate would move the transmit watermark to 32 or 128, or the receive watermark to 64. It drains the receive level across the threshold without a clock edge in between. A design that latched the status bits would keep the interrupt raised, so no new edge would follow. It writes all ones to the interrupt word while the queue conditions hold, which catches a design that clears read-only bits, and it lines up an event with its own clear to pin down which one wins. The injected test pulse must last exactly one cycle on the status bits yet persist on the event bits.

// File: rtl/uart_irq_pkg.sv
// Package: uart_irq_pkg
// Shared bit positions, register addresses and the status bundle of the
// UART interrupt controller. Assumes the status bits sit below the event bits.
package uart_irq_pkg;

    localparam int unsigned IRQ_TX_WM    = 0;
    localparam int unsigned IRQ_RX_WM    = 1;
    localparam int unsigned IRQ_TX_EMPTY = 2;
    localparam int unsigned NUM_STATUS   = 3;

    typedef enum logic [1:0] {
        ADDR_STATE  = 2'd0,
        ADDR_ENABLE = 2'd1,
        ADDR_TEST   = 2'd2,
        ADDR_RSVD   = 2'd3
    } reg_addr_e;

    // Packed so that tx_wm lands on bit 0 and tx_empty on bit 2.
    typedef struct packed {
        logic tx_empty;
        logic rx_wm;
        logic tx_wm;
    } status_t;

endpackage

// File: rtl/uart_irq_thresh.sv
// Module: uart_irq_thresh
// Decodes a watermark level code to a threshold of 2^code, clamped to SAT.
// With HAS_OFF set, the all-ones code marks the watermark as inactive.
// Assumes SAT fits in the threshold width derived from DEPTH.
module uart_irq_thresh #(
    parameter int unsigned DEPTH   = 32,
    parameter int unsigned SAT     = 16,
    parameter bit          HAS_OFF = 1'b0,
    parameter int unsigned CODE_W  = 3,
    localparam int unsigned TW     = $clog2(DEPTH + 1)
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [TW-1:0]     thr_o,
    output logic              active_o
);

    logic [31:0] pow_w;

    // Power-of-two threshold with saturation.
    always_comb begin
        pow_w = 32'd1 << code_i;
        if (pow_w > SAT) begin
            pow_w = SAT;
        end
        thr_o = pow_w[TW-1:0];
    end

    // Variant selection: the receive decoder has an off code, the transmit one does not.
    generate
        if (HAS_OFF) begin : g_off
            assign active_o = (code_i != '1);
        end else begin : g_on
            assign active_o = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/uart_irq_status.sv
// Module: uart_irq_status
// Forms the three level-type status bits from live queue levels and thresholds.
// Purely combinational, so the bits follow their inputs in the same cycle.
module uart_irq_status
    import uart_irq_pkg::*;
#(
    parameter int unsigned TX_DEPTH = 32,
    parameter int unsigned RX_DEPTH = 64,
    localparam int unsigned TX_LW   = $clog2(TX_DEPTH + 1),
    localparam int unsigned RX_LW   = $clog2(RX_DEPTH + 1)
) (
    input  logic [TX_LW-1:0] tx_level_i,
    input  logic [RX_LW-1:0] rx_level_i,
    input  logic [TX_LW-1:0] tx_thr_i,
    input  logic [RX_LW-1:0] rx_thr_i,
    input  logic             rx_active_i,
    output status_t          status_o
);

    // Level comparisons against the decoded thresholds.
    always_comb begin
        status_o.tx_wm    = (tx_level_i < tx_thr_i);
        status_o.rx_wm    = rx_active_i && (rx_level_i >= rx_thr_i);
        status_o.tx_empty = (tx_level_i == '0);
    end

endmodule

// File: rtl/uart_irq_evt_bank.sv
// Module: uart_irq_evt_bank
// Holds the latched event bits: each one sets on a pulse or a test write and
// clears on write-1. A set in the same cycle overrides a clear.
module uart_irq_evt_bank #(
    parameter int unsigned NUM_EVT = 5
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [NUM_EVT-1:0] set_i,
    input  logic [NUM_EVT-1:0] clr_i,
    output logic [NUM_EVT-1:0] state_o
);

    generate
        for (genvar k = 0; k < NUM_EVT; k++) begin : g_bit
            // One sticky flag per event source.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    state_o[k] <= 1'b0;
                end else if (evt_i[k] || set_i[k]) begin
                    state_o[k] <= 1'b1;
                end else if (clr_i[k]) begin
                    state_o[k] <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/uart_irq_ctrl.sv
// Module: uart_irq_ctrl
// UART interrupt controller: combines live status bits with latched event bits
// into the interrupt word and gates them with the enable mask onto the request lines.
// Assumes the queue levels never exceed their depths and register accesses take one cycle.
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int unsigned TX_DEPTH = 32,
    parameter int unsigned RX_DEPTH = 64,
    parameter int unsigned NUM_EVT  = 5,
    parameter int unsigned CODE_W   = 3,
    localparam int unsigned TX_LW   = $clog2(TX_DEPTH + 1),
    localparam int unsigned RX_LW   = $clog2(RX_DEPTH + 1),
    localparam int unsigned NUM_IRQ = NUM_STATUS + NUM_EVT
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [TX_LW-1:0]   tx_level_i,
    input  logic [RX_LW-1:0]   rx_level_i,
    input  logic [CODE_W-1:0]  tx_lvl_code_i,
    input  logic [CODE_W-1:0]  rx_lvl_code_i,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               reg_we_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [NUM_IRQ-1:0] reg_wdata_i,
    output logic [NUM_IRQ-1:0] reg_rdata_o,
    output logic [NUM_IRQ-1:0] intr_state_o,
    output logic [NUM_IRQ-1:0] irq_o
);

    logic [TX_LW-1:0]      tx_thr;
    logic [RX_LW-1:0]      rx_thr;
    logic                  tx_active;
    logic                  rx_active;
    status_t               status;
    logic [NUM_STATUS-1:0] test_st_q;
    logic [NUM_IRQ-1:0]    enable_q;
    logic [NUM_EVT-1:0]    evt_state;
    logic [NUM_EVT-1:0]    evt_set;
    logic [NUM_EVT-1:0]    evt_clr;
    logic                  wr_state;
    logic                  wr_enable;
    logic                  wr_test;

    uart_irq_thresh #(
        .DEPTH   (TX_DEPTH),
        .SAT     (TX_DEPTH / 2),
        .HAS_OFF (1'b0),
        .CODE_W  (CODE_W)
    ) tx_thresh_i (
        .code_i   (tx_lvl_code_i),
        .thr_o    (tx_thr),
        .active_o (tx_active)
    );

    uart_irq_thresh #(
        .DEPTH   (RX_DEPTH),
        .SAT     (RX_DEPTH - 2),
        .HAS_OFF (1'b1),
        .CODE_W  (CODE_W)
    ) rx_thresh_i (
        .code_i   (rx_lvl_code_i),
        .thr_o    (rx_thr),
        .active_o (rx_active)
    );

    uart_irq_status #(
        .TX_DEPTH (TX_DEPTH),
        .RX_DEPTH (RX_DEPTH)
    ) status_i (
        .tx_level_i  (tx_level_i),
        .rx_level_i  (rx_level_i),
        .tx_thr_i    (tx_active ? tx_thr : '0),
        .rx_thr_i    (rx_thr),
        .rx_active_i (rx_active),
        .status_o    (status)
    );

    // Register write decode.
    always_comb begin
        wr_state  = reg_we_i && (reg_addr_i == ADDR_STATE);
        wr_enable = reg_we_i && (reg_addr_i == ADDR_ENABLE);
        wr_test   = reg_we_i && (reg_addr_i == ADDR_TEST);
        evt_clr   = wr_state ? reg_wdata_i[NUM_IRQ-1:NUM_STATUS] : '0;
        evt_set   = wr_test  ? reg_wdata_i[NUM_IRQ-1:NUM_STATUS] : '0;
    end

    uart_irq_evt_bank #(
        .NUM_EVT (NUM_EVT)
    ) evt_bank_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .evt_i   (evt_i),
        .set_i   (evt_set),
        .clr_i   (evt_clr),
        .state_o (evt_state)
    );

    // Enable mask register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            enable_q <= '0;
        end else if (wr_enable) begin
            enable_q <= reg_wdata_i;
        end
    end

    // One-cycle forced assertion of status bits from a test write.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            test_st_q <= '0;
        end else begin
            test_st_q <= wr_test ? reg_wdata_i[NUM_STATUS-1:0] : '0;
        end
    end

    // Interrupt word and gated request lines.
    always_comb begin
        intr_state_o = {evt_state, (NUM_STATUS'(status) | test_st_q)};
        irq_o        = intr_state_o & enable_q;
    end

    // Read data multiplexer.
    always_comb begin
        unique case (reg_addr_i)
            ADDR_STATE:  reg_rdata_o = intr_state_o;
            ADDR_ENABLE: reg_rdata_o = enable_q;
            default:     reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
// Module: uart_irq_ctrl_chk
// Port-level checker for uart_irq_ctrl, attached by bind. Tracks test writes
// so that the status checks skip the one cycle a test write may force.
module uart_irq_ctrl_chk #(
    parameter int unsigned TX_DEPTH = 32,
    parameter int unsigned RX_DEPTH = 64,
    parameter int unsigned NUM_EVT  = 5,
    parameter int unsigned CODE_W   = 3,
    localparam int unsigned TX_LW   = $clog2(TX_DEPTH + 1),
    localparam int unsigned RX_LW   = $clog2(RX_DEPTH + 1),
    localparam int unsigned NUM_IRQ = 3 + NUM_EVT
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [TX_LW-1:0]   tx_level_i,
    input logic [RX_LW-1:0]   rx_level_i,
    input logic [CODE_W-1:0]  rx_lvl_code_i,
    input logic [NUM_EVT-1:0] evt_i,
    input logic               reg_we_i,
    input logic [1:0]         reg_addr_i,
    input logic [NUM_IRQ-1:0] reg_wdata_i,
    input logic [NUM_IRQ-1:0] intr_state_o,
    input logic [NUM_IRQ-1:0] irq_o
);

    logic test_q;

    // Remembers that the previous cycle carried a test write touching status bits.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            test_q <= 1'b0;
        end else begin
            test_q <= reg_we_i && (reg_addr_i == 2'd2) && (|reg_wdata_i[2:0]);
        end
    end

    AST_TX_EMPTY_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !test_q |-> (intr_state_o[2] == (tx_level_i == '0))); // R1

    AST_TX_WM_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!test_q && (tx_level_i >= TX_LW'(TX_DEPTH / 2))) |-> !intr_state_o[0]); // R2

    AST_RX_WM_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!test_q && (rx_lvl_code_i != '1) && (rx_level_i >= RX_LW'(RX_DEPTH - 2)))
        |-> intr_state_o[1]); // R3

    AST_RX_WM_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!test_q && (rx_lvl_code_i == '1)) |-> !intr_state_o[1]); // R4

    AST_EVT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|evt_i) |=> (({$past(evt_i), 3'b000} & ~intr_state_o) == '0)); // R6

    AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((irq_o & ~intr_state_o) == '0)); // R10

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(
    .TX_DEPTH (TX_DEPTH),
    .RX_DEPTH (RX_DEPTH),
    .NUM_EVT  (NUM_EVT),
    .CODE_W   (CODE_W)
) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tx_level_i    (tx_level_i),
    .rx_level_i    (rx_level_i),
    .rx_lvl_code_i (rx_lvl_code_i),
    .evt_i         (evt_i),
    .reg_we_i      (reg_we_i),
    .reg_addr_i    (reg_addr_i),
    .reg_wdata_i   (reg_wdata_i),
    .intr_state_o  (intr_state_o),
    .irq_o         (irq_o)
);

// File: tb/uart_irq_ctrl_tb.sv
// Bench: uart_irq_ctrl_tb_top
// Directed corner cases followed by seeded random traffic, all compared each
// cycle against a bench model built from the requirements.
module uart_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TX_SAT     = 16;
    localparam int RX_SAT     = 62;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] tx_level = '0;
    logic [6:0] rx_level = '0;
    logic [2:0] tx_code = '0;
    logic [2:0] rx_code = '0;
    logic [4:0] evt = '0;
    logic       we = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] state;
    logic [7:0] irq;

    logic [4:0] m_evt = '0;
    logic [7:0] m_en  = '0;
    logic [2:0] m_tst = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_irq_ctrl dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .tx_level_i    (tx_level),
        .rx_level_i    (rx_level),
        .tx_lvl_code_i (tx_code),
        .rx_lvl_code_i (rx_code),
        .evt_i         (evt),
        .reg_we_i      (we),
        .reg_addr_i    (addr),
        .reg_wdata_i   (wdata),
        .reg_rdata_o   (rdata),
        .intr_state_o  (state),
        .irq_o         (irq)
    );

    function automatic int tx_thr(input logic [2:0] c);
        int p = 1 << c;
        return (p > TX_SAT) ? TX_SAT : p;
    endfunction

    function automatic int rx_thr(input logic [2:0] c);
        int p = 1 << c;
        return (p > RX_SAT) ? RX_SAT : p;
    endfunction

    function automatic logic [2:0] exp_status();
        logic [2:0] s;
        s[0] = int'(tx_level) < tx_thr(tx_code);
        s[1] = (rx_code != 3'd7) && (int'(rx_level) >= rx_thr(rx_code));
        s[2] = (tx_level == 6'd0);
        return s;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Compare all outputs just after the inputs settle, then advance one clock.
    task automatic cyc(input string tag);
        logic [7:0] es;
        logic [4:0] clr;
        logic [4:0] tset;
        #2;
        es = {m_evt, exp_status() | m_tst};
        chk(tag, "state", state, es);
        chk(tag, "irq", irq, es & m_en);
        chk(tag, "rdata", rdata, (addr == 2'd0) ? es : (addr == 2'd1) ? m_en : 8'h00);
        @(posedge clk);
        clr   = (we && addr == 2'd0) ? wdata[7:3] : 5'd0;
        tset  = (we && addr == 2'd2) ? wdata[7:3] : 5'd0;
        m_tst = (we && addr == 2'd2) ? wdata[2:0] : 3'd0;
        m_evt = (m_evt & ~clr) | evt | tset;
        if (we && addr == 2'd1) m_en = wdata;
        @(negedge clk);
    endtask

    task automatic idle();
        we = 1'b0; evt = '0; addr = 2'd0; wdata = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
        we = 1'b1; addr = a; wdata = d;
        cyc(tag);
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Reset state: no events, mask clear, no request lines.
        cyc("R11");
        chk("R11", "irq literal", irq, 8'h00);

        // Transmit empty follows level 0.
        tx_level = 6'd0; cyc("R1");
        tx_level = 6'd1; cyc("R1");
        chk("R1", "empty bit", {7'd0, state[2]}, 8'h00);

        // Transmit watermark edges for every code, including saturated ones.
        for (int c = 0; c < 8; c++) begin
            tx_code = 3'(c);
            tx_level = 6'(tx_thr(3'(c)) - 1); cyc("R2");
            tx_level = 6'(tx_thr(3'(c)));     cyc("R2");
        end
        tx_code = 3'd7; tx_level = 6'd15; #1;
        chk("R2", "sat bit", {7'd0, state[0]}, 8'h01);
        cyc("R2");

        // Receive watermark edges for codes 0..6.
        for (int c = 0; c < 7; c++) begin
            rx_code = 3'(c);
            rx_level = 7'(rx_thr(3'(c)) - 1); cyc("R3");
            rx_level = 7'(rx_thr(3'(c)));     cyc("R3");
        end
        rx_level = 7'd64; cyc("R3");

        // Receive code 7 switches the receive watermark off.
        rx_code = 3'd7; rx_level = 7'd64; cyc("R4");
        rx_level = 7'd0; cyc("R4");

        // Drain across the threshold without a clock edge in between.
        rx_code = 3'd6; rx_level = 7'd62; #1;
        chk("R5", "rx bit high", {7'd0, state[1]}, 8'h01);
        rx_level = 7'd61; #1;
        chk("R5", "rx bit low", {7'd0, state[1]}, 8'h00);
        cyc("R5");

        // Event pulses latch and stay.
        for (int k = 0; k < 5; k++) begin
            evt = 5'(1 << k); cyc("R6");
            evt = '0;         cyc("R6");
            cyc("R6");
        end

        // Write-1 clear: status bits read-only, event bits selective.
        tx_level = 6'd0; tx_code = 3'd2; rx_code = 3'd0; rx_level = 7'd5;
        wr(2'd0, 8'b0000_1111, "R7");
        cyc("R7");
        chk("R7", "state literal", state, 8'b1111_0111);
        wr(2'd0, 8'hFF, "R7");
        cyc("R7");

        // Event and clear of the same bit in one cycle: set wins.
        evt = 5'b00001; we = 1'b1; addr = 2'd0; wdata = 8'h08;
        cyc("R8");
        idle();
        cyc("R8");
        chk("R8", "evt bit", {7'd0, state[3]}, 8'h01);
        wr(2'd0, 8'hFF, "R8");

        // Test write with status conditions false: one-cycle force.
        tx_level = 6'd20; tx_code = 3'd0; rx_code = 3'd7; rx_level = 7'd3;
        wr(2'd2, 8'hFF, "R9");
        chk("R9", "forced", state, 8'hFF);
        cyc("R9");
        chk("R9", "after force", state, 8'hF8);
        wr(2'd0, 8'hFF, "R9");

        // Enable mask, readback and gated lines.
        wr(2'd1, 8'b1010_0101, "R10");
        addr = 2'd1; cyc("R10");
        addr = 2'd3; cyc("R10");
        evt = 5'b10100; cyc("R10");
        idle(); cyc("R10");
        wr(2'd0, 8'hFF, "R10");

        // Seeded random traffic.
        for (int i = 0; i < 3000; i++) begin
            tx_level = 6'($urandom_range(0, 32));
            rx_level = 7'($urandom_range(0, 64));
            tx_code  = 3'($urandom_range(0, 7));
            rx_code  = 3'($urandom_range(0, 7));
            evt      = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'd0;
            we       = ($urandom_range(0, 3) == 0);
            addr     = 2'($urandom_range(0, 3));
            wdata    = 8'($urandom);
            cyc("R5");
        end
        idle();
        cyc("R10");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule